// File: doc/BRIEF.md
# Variable-Partition SAD Motion Engine

This block scores candidate motion vectors for one 16×16 macroblock. Each cycle it can take a 128-bit row of sixteen 8-bit current-block pixels, the matching row of reference pixels and a motion-vector tag for the candidate being scored. The reference pixels must already be interpolated. The block forms sixteen 4×4 absolute-difference sums and keeps them in registers while the rows arrive. After the sixteenth row of a candidate it adds these sums into all 41 partition costs of the standard partition sizes. For each partition it keeps the lowest cost seen and the vector that gave it.

A search opens with a start pulse. Candidates then follow one after another, and the search ends with the candidate flagged as last, or with the ninth candidate in refinement mode. A one-cycle done strobe marks the end. The 41 winning costs and vectors can then be read one at a time through a combinational index port. In refinement mode the block scores a centre position and its eight neighbours. It numbers them itself, in arrival order, and reports the number of the cheapest one.

Top module: `sad_motion_engine`

## Requirements
- R1: A row is accepted on every clock edge at which row_valid is high, with no gaps required. Rows are numbered 0 to 15 in arrival order, counting from reset or from start. Pixel x of a row (x = 0..15) occupies bits [8x+7:8x]. Row y covers picture line y of the block.
- R2: Partition index p maps as follows. 0 is 16×16. 1 and 2 are the top and bottom 16×8. 3 and 4 are the left and right 8×16. 5 to 8 are the 8×8 quadrants q in raster order. 9+2q+h is the 8×4 half h (top 0, bottom 1) of quadrant q. 17+2q+s is the 4×8 half s (left 0, right 1) of quadrant q. 25+b is the 4×4 block b in raster order.
- R3: Every partition cost of a candidate equals the sum of |cur−ref| over the pixels of that partition, and all 41 costs come from one pass over the 16 rows.
- R4: The 16×16 cost reaches its maximum of 65280 without wrapping.
- R5: Each partition keeps the lowest cost seen so far and the vector that produced it. A new cost replaces the stored one only if it is strictly lower, so on a tie the earlier candidate stays. After reset every slot holds cost 65535 and vector 0.
- R6: A start pulse returns every slot to cost 65535 and vector 0 and restarts the row numbering.
- R7: A candidate may follow the previous one with no idle cycle, and idle cycles may appear between rows of a candidate. Neither changes any result.
- R8: done is high for exactly one cycle. It rises after the second clock edge following the edge that accepted row 15 of the last candidate. last_cand is sampled together with row 15.
- R9: When refine_en is high at start, the block numbers candidates 0 to 8 in arrival order. Each slot stores this number in place of mv_tag. done follows the ninth candidate whatever last_cand says, later candidates change nothing, and best_dir shows the number stored for the 16×16 slot.
- R10: A read index of 41 or more returns cost 0 and vector 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Opens a new search and clears all trackers |
| refine_en | input | 1 | Selects nine-position refinement mode, sampled with start |
| row_valid | input | 1 | A pixel row is present |
| cur_row | input | 128 | Sixteen current-block pixels |
| ref_row | input | 128 | Sixteen reference pixels |
| mv_tag | input | MV_W | Vector tag of the candidate, sampled with row 15 |
| last_cand | input | 1 | Marks the final candidate, sampled with row 15 |
| rd_idx | input | 6 | Partition index to read |
| done | output | 1 | One-cycle end-of-search strobe |
| rd_cost | output | 16 | Best cost of the indexed partition |
| rd_mv | output | MV_W | Vector of that best cost |
| best_dir | output | 4 | Refinement direction number held by the 16×16 slot |

## Verification
The first candidate of a search is fully random. Because it is the only candidate, all 41 readouts equal its own costs, which exposes any wrong partition mapping or bit placement. A uniform worst-case block exposes wrap-around in the widest sums. A sequence of random candidates sent back to back shows whether the trackers pick the minimum for each partition independently, and an identical pair of candidates tells strict from non-strict comparison. Gapped rows, a bare start, a refinement run whose tenth candidate would win if it were counted, and out-of-range reads each isolate one control path.

// File: rtl/sad_me_pkg.sv
package sad_me_pkg;
  localparam int PIX_W   = 8;
  localparam int ROW_PIX = 16;
  localparam int GRP_PIX = 4;
  localparam int GRP_N   = ROW_PIX / GRP_PIX;
  localparam int BLK_N   = GRP_N * GRP_N;
  localparam int PART_N  = 41;
  localparam int GRP_W   = PIX_W + $clog2(GRP_PIX);
  localparam int BLK_W   = GRP_W + $clog2(GRP_PIX);
  localparam int COST_W  = 16;
  localparam int IDX_W   = $clog2(PART_N);
  localparam int ROW_W   = $clog2(ROW_PIX);

  typedef logic [BLK_N-1:0][BLK_W-1:0] blk_vec_t;
  typedef logic [GRP_N-1:0][GRP_W-1:0] grp_vec_t;

  function automatic logic [PIX_W-1:0] abs_diff(input logic [PIX_W-1:0] a,
                                                input logic [PIX_W-1:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  function automatic logic [GRP_W-1:0] group_sad(input logic [GRP_PIX*PIX_W-1:0] c,
                                                 input logic [GRP_PIX*PIX_W-1:0] r);
    logic [GRP_W-1:0] s;
    s = '0;
    for (int i = 0; i < GRP_PIX; i++)
      s = s + GRP_W'(abs_diff(c[i*PIX_W +: PIX_W], r[i*PIX_W +: PIX_W]));
    return s;
  endfunction

  // Which 4x4 blocks make up partition idx (block b = 4*row + col).
  function automatic logic [BLK_N-1:0] part_mask(input int idx);
    logic [BLK_N-1:0] m;
    int br, bc, k, q;
    m = '0;
    for (int b = 0; b < BLK_N; b++) begin
      br = b / GRP_N;
      bc = b % GRP_N;
      if (idx == 0) m[b] = 1'b1;
      else if (idx < 3) m[b] = (br / 2 == idx - 1);
      else if (idx < 5) m[b] = (bc / 2 == idx - 3);
      else if (idx < 9) begin
        q = idx - 5;
        m[b] = (br / 2 == q / 2) && (bc / 2 == q % 2);
      end else if (idx < 17) begin
        k = idx - 9;
        q = k / 2;
        m[b] = (br / 2 == q / 2) && (bc / 2 == q % 2) && (br % 2 == k % 2);
      end else if (idx < 25) begin
        k = idx - 17;
        q = k / 2;
        m[b] = (br / 2 == q / 2) && (bc / 2 == q % 2) && (bc % 2 == k % 2);
      end else m[b] = (b == idx - 25);
    end
    return m;
  endfunction

  function automatic logic [COST_W-1:0] part_cost(input blk_vec_t v, input int idx);
    logic [BLK_N-1:0] m;
    logic [COST_W-1:0] s;
    m = part_mask(idx);
    s = '0;
    for (int b = 0; b < BLK_N; b++)
      if (m[b]) s = s + COST_W'(v[b]);
    return s;
  endfunction
endpackage

// File: rtl/sad_row_stage.sv
module sad_row_stage
  import sad_me_pkg::*;
#(
  parameter int MV_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       in_valid,
  input  logic [ROW_PIX*PIX_W-1:0]   cur_row,
  input  logic [ROW_PIX*PIX_W-1:0]   ref_row,
  input  logic [MV_W-1:0]            in_mv,
  input  logic                       in_last,
  output logic                       s1_valid,
  output logic [ROW_W-1:0]           s1_row,
  output grp_vec_t                   s1_grp,
  output logic [MV_W-1:0]            s1_mv,
  output logic                       s1_last
);
  localparam int GRP_BITS = GRP_PIX * PIX_W;

  logic [ROW_W-1:0] row_cnt;
  grp_vec_t         grp_d;

  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    assign grp_d[g] = group_sad(cur_row[g*GRP_BITS +: GRP_BITS],
                                ref_row[g*GRP_BITS +: GRP_BITS]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_cnt  <= '0;
      s1_valid <= 1'b0;
      s1_row   <= '0;
      s1_grp   <= '0;
      s1_mv    <= '0;
      s1_last  <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      if (start) row_cnt <= '0;
      else if (in_valid) row_cnt <= row_cnt + 1'b1;
      if (in_valid) begin
        s1_row  <= row_cnt;
        s1_grp  <= grp_d;
        s1_mv   <= in_mv;
        s1_last <= in_last;
      end
    end
  end
endmodule

// File: rtl/sad_block_accum.sv
module sad_block_accum
  import sad_me_pkg::*;
#(
  parameter int MV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s1_valid,
  input  logic [ROW_W-1:0]  s1_row,
  input  grp_vec_t          s1_grp,
  input  logic [MV_W-1:0]   s1_mv,
  input  logic              s1_last,
  output blk_vec_t          acc,
  output logic              eval,
  output logic [MV_W-1:0]   ev_mv,
  output logic              ev_last
);
  localparam int BR_W = ROW_W - 2;

  logic [BR_W-1:0] band;
  logic [1:0]      sub;
  logic            row_end;

  assign band    = s1_row[ROW_W-1:2];
  assign sub     = s1_row[1:0];
  assign row_end = s1_valid && (s1_row == ROW_W'(ROW_PIX - 1));

  for (genvar b = 0; b < BLK_N; b++) begin : g_blk
    localparam int BR = b / GRP_N;
    localparam int BC = b % GRP_N;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc[b] <= '0;
      else if (s1_valid && band == BR_W'(BR)) begin
        if (sub == 2'd0) acc[b] <= BLK_W'(s1_grp[BC]);
        else             acc[b] <= acc[b] + BLK_W'(s1_grp[BC]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eval    <= 1'b0;
      ev_mv   <= '0;
      ev_last <= 1'b0;
    end else begin
      eval <= row_end;
      if (row_end) begin
        ev_mv   <= s1_mv;
        ev_last <= s1_last;
      end
    end
  end
endmodule

// File: rtl/sad_best_slot.sv
module sad_best_slot
  import sad_me_pkg::*;
#(
  parameter int MV_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               upd,
  input  logic [COST_W-1:0]  cost,
  input  logic [MV_W-1:0]    mv,
  output logic [COST_W-1:0]  best_cost,
  output logic [MV_W-1:0]    best_mv
);
  logic wins;
  assign wins = upd && (cost < best_cost);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_cost <= '1;
      best_mv   <= '0;
    end else if (clear) begin
      best_cost <= '1;
      best_mv   <= '0;
    end else if (wins) begin
      best_cost <= cost;
      best_mv   <= mv;
    end
  end
endmodule

// File: rtl/sad_motion_engine.sv
module sad_motion_engine
  import sad_me_pkg::*;
#(
  parameter int MV_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      refine_en,
  input  logic                      row_valid,
  input  logic [ROW_PIX*PIX_W-1:0]  cur_row,
  input  logic [ROW_PIX*PIX_W-1:0]  ref_row,
  input  logic [MV_W-1:0]           mv_tag,
  input  logic                      last_cand,
  input  logic [IDX_W-1:0]          rd_idx,
  output logic                      done,
  output logic [COST_W-1:0]         rd_cost,
  output logic [MV_W-1:0]           rd_mv,
  output logic [3:0]                best_dir
);
  localparam int REF_POS = 9;

  logic                       s1_valid;
  logic [ROW_W-1:0]           s1_row;
  grp_vec_t                   s1_grp;
  logic [MV_W-1:0]            s1_mv;
  logic                       s1_last;
  blk_vec_t                   acc;
  logic                       eval;
  logic [MV_W-1:0]            ev_mv;
  logic                       ev_last;
  logic                       refine_q;
  logic [3:0]                 ref_cnt;
  logic                       eval_fire;
  logic                       search_end;
  logic [MV_W-1:0]            upd_mv;
  logic [PART_N-1:0][COST_W-1:0] cost_vec;
  logic [COST_W-1:0]          best_cost_arr [PART_N];
  logic [MV_W-1:0]            best_mv_arr   [PART_N];
  logic [COST_W-1:0]          best0_cost;

  sad_row_stage #(.MV_W(MV_W)) u_row (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(row_valid),
    .cur_row(cur_row), .ref_row(ref_row), .in_mv(mv_tag), .in_last(last_cand),
    .s1_valid(s1_valid), .s1_row(s1_row), .s1_grp(s1_grp),
    .s1_mv(s1_mv), .s1_last(s1_last)
  );

  sad_block_accum #(.MV_W(MV_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_row(s1_row),
    .s1_grp(s1_grp), .s1_mv(s1_mv), .s1_last(s1_last),
    .acc(acc), .eval(eval), .ev_mv(ev_mv), .ev_last(ev_last)
  );

  assign eval_fire  = eval && (!refine_q || ref_cnt < 4'(REF_POS));
  assign search_end = eval_fire && (refine_q ? (ref_cnt == 4'(REF_POS - 1)) : ev_last);
  assign upd_mv     = refine_q ? MV_W'(ref_cnt) : ev_mv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refine_q <= 1'b0;
      ref_cnt  <= '0;
      done     <= 1'b0;
    end else begin
      done <= search_end;
      if (start) begin
        refine_q <= refine_en;
        ref_cnt  <= '0;
      end else if (eval_fire && refine_q) begin
        ref_cnt <= ref_cnt + 1'b1;
      end
    end
  end

  for (genvar p = 0; p < PART_N; p++) begin : g_part
    assign cost_vec[p] = part_cost(acc, p);
    sad_best_slot #(.MV_W(MV_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .clear(start), .upd(eval_fire),
      .cost(cost_vec[p]), .mv(upd_mv),
      .best_cost(best_cost_arr[p]), .best_mv(best_mv_arr[p])
    );
  end

  assign best0_cost = best_cost_arr[0];
  assign best_dir   = best_mv_arr[0][3:0];

  always_comb begin
    rd_cost = '0;
    rd_mv   = '0;
    if (rd_idx < IDX_W'(PART_N)) begin
      rd_cost = best_cost_arr[rd_idx];
      rd_mv   = best_mv_arr[rd_idx];
    end
  end
endmodule

// File: rtl/sad_engine_checker.sv
module sad_engine_checker
  import sad_me_pkg::*;
(
  input logic                          clk,
  input logic                          rst_n,
  input logic                          start,
  input logic                          done,
  input logic                          eval_fire,
  input logic [3:0]                    ref_cnt,
  input logic [PART_N-1:0][COST_W-1:0] cost_vec,
  input logic [COST_W-1:0]             best0_cost
);
  assert_done_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_eval_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(eval_fire));

  assert_quad_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eval_fire |-> (cost_vec[0] == cost_vec[5] + cost_vec[6] + cost_vec[7] + cost_vec[8]));

  assert_half_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eval_fire |-> (cost_vec[1] == cost_vec[9] + cost_vec[10] + cost_vec[11] + cost_vec[12]));

  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eval_fire |-> (cost_vec[0] <= 16'd65280));

  assert_best_never_rises_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (best0_cost <= $past(best0_cost)));

  assert_refine_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cnt <= 4'd9);
endmodule

bind sad_motion_engine sad_engine_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .eval_fire(eval_fire),
  .ref_cnt(ref_cnt), .cost_vec(cost_vec), .best0_cost(best0_cost)
);

// File: tb/tb_sad_motion_engine.sv
module tb_sad_motion_engine;
  localparam int MV_W = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, refine_en = 1'b0, row_valid = 1'b0;
  logic [127:0] cur_row = '0, ref_row = '0;
  logic [MV_W-1:0] mv_tag = '0;
  logic last_cand = 1'b0;
  logic [5:0] rd_idx = '0;
  logic done;
  logic [15:0] rd_cost;
  logic [MV_W-1:0] rd_mv;
  logic [3:0] best_dir;

  int total = 0, bad = 0;
  logic [7:0] cur_mb [256];
  logic [7:0] ref_mb [256];
  int exp_cost [41];
  int exp_mv   [41];
  bit exp_refine = 0;
  int exp_cnt = 0;

  always #5 clk = ~clk;

  sad_motion_engine #(.MV_W(MV_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .refine_en(refine_en),
    .row_valid(row_valid), .cur_row(cur_row), .ref_row(ref_row),
    .mv_tag(mv_tag), .last_cand(last_cand), .rd_idx(rd_idx),
    .done(done), .rd_cost(rd_cost), .rd_mv(rd_mv), .best_dir(best_dir)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Rectangle of partition p: x0, y0, width, height.
  function automatic int bench_cost(input int p);
    int x0, y0, w, h, k, q, s, d;
    if (p == 0) begin x0 = 0; y0 = 0; w = 16; h = 16; end
    else if (p <= 2) begin x0 = 0; y0 = 8 * (p - 1); w = 16; h = 8; end
    else if (p <= 4) begin x0 = 8 * (p - 3); y0 = 0; w = 8; h = 16; end
    else if (p <= 8) begin q = p - 5; x0 = 8 * (q % 2); y0 = 8 * (q / 2); w = 8; h = 8; end
    else if (p <= 16) begin
      k = p - 9; q = k / 2; x0 = 8 * (q % 2); y0 = 8 * (q / 2) + 4 * (k % 2); w = 8; h = 4;
    end else if (p <= 24) begin
      k = p - 17; q = k / 2; x0 = 8 * (q % 2) + 4 * (k % 2); y0 = 8 * (q / 2); w = 4; h = 8;
    end else begin k = p - 25; x0 = 4 * (k % 4); y0 = 4 * (k / 4); w = 4; h = 4; end
    s = 0;
    for (int y = y0; y < y0 + h; y++)
      for (int x = x0; x < x0 + w; x++) begin
        d = int'(cur_mb[y*16+x]) - int'(ref_mb[y*16+x]);
        s += (d < 0) ? -d : d;
      end
    return s;
  endfunction

  task automatic do_start(input bit refine);
    @(negedge clk);
    start = 1'b1; refine_en = refine;
    @(negedge clk);
    start = 1'b0; refine_en = 1'b0;
    exp_refine = refine; exp_cnt = 0;
    for (int p = 0; p < 41; p++) begin exp_cost[p] = 65535; exp_mv[p] = 0; end
  endtask

  task automatic send_cand(input int mv, input bit last, input int gap);
    int tag;
    for (int y = 0; y < 16; y++) begin
      repeat (gap) begin @(negedge clk); row_valid = 1'b0; end
      @(negedge clk);
      row_valid = 1'b1;
      for (int x = 0; x < 16; x++) begin
        cur_row[8*x +: 8] = cur_mb[y*16+x];
        ref_row[8*x +: 8] = ref_mb[y*16+x];
      end
      mv_tag = MV_W'(mv); last_cand = last;
    end
    if (!exp_refine || exp_cnt < 9) begin
      tag = exp_refine ? exp_cnt : mv;
      for (int p = 0; p < 41; p++)
        if (bench_cost(p) < exp_cost[p]) begin exp_cost[p] = bench_cost(p); exp_mv[p] = tag; end
      if (exp_refine) exp_cnt++;
    end
  endtask

  task automatic wait_done(input string req, input bit expect_done);
    @(negedge clk); row_valid = 1'b0; last_cand = 1'b0;
    chk({req, " done low 1"}, int'(done), 0);
    @(negedge clk); chk({req, " done low 2"}, int'(done), 0);
    @(negedge clk); chk({req, " done pulse"}, int'(done), int'(expect_done));
    @(negedge clk); chk({req, " done drop"}, int'(done), 0);
  endtask

  task automatic check_all(input string req);
    for (int p = 0; p < 41; p++) begin
      rd_idx = 6'(p); #1;
      chk($sformatf("%s cost p%0d", req, p), int'(rd_cost), exp_cost[p]);
      chk($sformatf("%s mv p%0d", req, p), int'(rd_mv), exp_mv[p]);
    end
  endtask

  task automatic rand_mb(input bit cur_too);
    for (int i = 0; i < 256; i++) begin
      if (cur_too) cur_mb[i] = 8'($urandom);
      ref_mb[i] = 8'($urandom);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed_v;
    seed_v = int'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // Reset state (R5)
    @(negedge clk);
    chk("R5 reset done", int'(done), 0);
    rd_idx = 6'd0; #1;
    chk("R5 reset cost", int'(rd_cost), 65535);
    chk("R5 reset mv", int'(rd_mv), 0);

    // Single random candidate: mapping and sums (R1 R2 R3)
    do_start(0);
    rand_mb(1);
    send_cand(16'h1234, 1, 0);
    wait_done("R8 single", 1);
    check_all("R2 R3 single");

    // Worst-case block (R4)
    do_start(0);
    for (int i = 0; i < 256; i++) begin cur_mb[i] = 8'hFF; ref_mb[i] = 8'h00; end
    send_cand(7, 1, 0);
    wait_done("R8 max", 1);
    rd_idx = 6'd0; #1; chk("R4 max 16x16", int'(rd_cost), 65280);
    rd_idx = 6'd25; #1; chk("R4 max 4x4", int'(rd_cost), 4080);

    // Back-to-back random candidates (R5 R7 R1)
    do_start(0);
    rand_mb(1);
    for (int c = 0; c < 6; c++) begin
      rand_mb(0);
      send_cand(100 + c, c == 5, 0);
    end
    wait_done("R8 seq", 1);
    check_all("R5 R7 seq");

    // Tie keeps earlier (R5)
    do_start(0);
    rand_mb(1);
    send_cand(1, 0, 0);
    send_cand(2, 1, 0);
    wait_done("R8 tie", 1);
    check_all("R5 tie");

    // Gapped rows (R7)
    do_start(0);
    rand_mb(1);
    send_cand(55, 0, 2);
    rand_mb(0);
    send_cand(66, 1, 1);
    wait_done("R8 gap", 1);
    check_all("R7 gap");

    // Bare start clears (R6)
    do_start(0);
    rd_idx = 6'd0; #1; chk("R6 clear cost", int'(rd_cost), 65535);
    chk("R6 clear mv", int'(rd_mv), 0);
    rd_idx = 6'd40; #1; chk("R6 clear cost 4x4", int'(rd_cost), 65535);

    // Refinement mode (R9)
    do_start(1);
    rand_mb(1);
    for (int c = 0; c < 9; c++) begin
      rand_mb(0);
      send_cand(999, 0, 0);
    end
    wait_done("R9 refine", 1);
    check_all("R9 refine");
    #1 chk("R9 best_dir", int'(best_dir), exp_mv[0]);
    for (int i = 0; i < 256; i++) ref_mb[i] = cur_mb[i];
    send_cand(999, 1, 0);
    wait_done("R9 tenth ignored", 0);
    check_all("R9 after tenth");

    // Out-of-range read (R10)
    rd_idx = 6'd41; #1;
    chk("R10 idx41 cost", int'(rd_cost), 0);
    chk("R10 idx41 mv", int'(rd_mv), 0);
    rd_idx = 6'd63; #1;
    chk("R10 idx63 cost", int'(rd_cost), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule